// File: doc/BRIEF.md
# Cell Measurement Loop Sequencer

This block runs the repeating voltage measurement loop of a battery-stack monitor. Once per time slot it sends one conversion request, with a channel code, to an external voltage converter. When the converter reports completion, the returned word is stored in a per-channel result bank that the rest of the chip reads through a small read port. Each loop first covers all series cells in ascending order. It then covers the auxiliary nodes: stack top, pack terminal, load terminal, the internal references, and finally whichever general-purpose or thermistor inputs are enabled in a mask.

Slot timing comes from a clock prescaler that produces ticks. A slot is a fixed number of ticks, and that number is halved when fast conversion mode is selected. One tick before a cell's slot begins, the block raises a pause bit for that cell so the balancing controller can turn off bypass current. The bit stays high until the converter reports the cell's result. When the last enabled slot of a loop ends, a one-clock loop-complete pulse is issued and the loop starts again at the first cell.

The enable mask and the fast-mode setting are sampled only at a loop boundary. A loop therefore never mixes two configurations.

Top module: `cell_meas_loop_seq`

## Requirements
- R1: Each loop requests the cell channels first, in ascending order. Cell n (counting from 1) uses channel code n-1, so the codes run 0 to NUM_CELLS-1.
- R2: After the cells, the loop requests these channels in order: stack top (code NUM_CELLS), pack (NUM_CELLS+1), load (NUM_CELLS+2), and the references (the next NUM_REFS codes). It then requests each auxiliary input k whose `cfg_aux_en[k]` is 1, in ascending k, with code NUM_CELLS+3+NUM_REFS+k. Disabled inputs take no slot.
- R3: Consecutive requests are SLOT_TICKS×PRESCALE clocks apart in normal mode. In fast mode they are (SLOT_TICKS/2)×PRESCALE clocks apart. The spacing is set by the mode of the loop that holds the earlier slot.
- R4: `adc_req` is a one-clock pulse, issued once per slot. `adc_ch` keeps its value until the next request.
- R5: `bal_pause[c]` rises exactly PRESCALE clocks (one tick) before the request for cell channel c. It stays high through the request and is low on the clock after `adc_done` for that channel. At most two pause bits are high at once.
- R6: `loop_done` is a one-clock pulse in the same cycle as the channel-0 request that starts each new loop. It does not fire for the first loop after reset, and it is never high at any other time.
- R7: A change to `cfg_fast` or `cfg_aux_en` made during a loop does not affect that loop. It applies to the next loop, both to the channel list and to the slot length.
- R8: When `adc_done` arrives with a request outstanding, `adc_data` is written into the bank entry of the requested channel. `rd_data` shows the entry selected by `rd_ch`, and shows 0 for codes of NUM_CH or above. Entries not converted keep their value. A `adc_done` with no request outstanding changes nothing.
- R9: While reset is held, `adc_req`, `loop_done` and every `bal_pause` bit are 0, and every bank entry reads 0. The first request after reset goes to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fast | input | 1 | Fast conversion mode (half-length slots), sampled at loop start |
| cfg_aux_en | input | NUM_AUX_IN | Enable for each auxiliary input, sampled at loop start |
| adc_req | output | 1 | One-clock conversion request |
| adc_ch | output | CH_W | Channel code of the current request |
| adc_done | input | 1 | Converter completion strobe |
| adc_data | input | DATA_W | Conversion result, valid with adc_done |
| bal_pause | output | NUM_CELLS | Per-cell balancing hold-off |
| loop_done | output | 1 | One-clock pulse at the start of each new loop |
| rd_ch | input | CH_W | Result bank read select |
| rd_data | output | DATA_W | Result bank read data |

## Verification
The scoreboard first pushes the exact channel list and request spacing for each loop. It then changes the mask and the mode in the middle of a loop. A design that applied the new configuration at once would lengthen or shorten the running loop, or change its slot timing, and the next popped channel or gap would not match. The bench measures the lead of each pause bit against its request, to the exact number of clocks. A pause raised on the slot's own tick, or cleared by the previous cell's completion, would show a zero lead or a missing bit. A completion strobe is injected while no conversion is outstanding, and disabled auxiliary entries are read back after they have dropped out of the loop. Either check catches a bank that writes on every strobe or one that clears entries it does not convert.

// File: rtl/cml_pkg.sv
package cml_pkg;

  // Stack top, pack and load nodes sit between the cells and the references.
  localparam int FIXED_NODES = 3;

  // Ticks in one slot for the selected conversion speed.
  function automatic int slot_ticks(input int base_ticks, input logic fast);
    return fast ? (base_ticks / 2) : base_ticks;
  endfunction

  // Position that follows pos in the loop. Returns 0 when the loop wraps.
  function automatic int next_slot(input int pos, input logic [31:0] aux_en,
                                   input int first_in, input int n_in);
    int nxt;
    nxt = 0;
    if (pos < first_in - 1) begin
      nxt = pos + 1;
    end else begin
      for (int k = 31; k >= 0; k--) begin
        if (k < n_in && aux_en[k] && (first_in + k) > pos) nxt = first_in + k;
      end
    end
    return nxt;
  endfunction

endpackage

// File: rtl/cml_tick_gen.sv
module cml_tick_gen #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [CW-1:0] div_q;

  assign tick = (int'(div_q) == PRESCALE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3

endmodule

// File: rtl/cml_slot_sched.sv
module cml_slot_sched #(
  parameter int NUM_CELLS  = 16,
  parameter int NUM_REFS   = 1,
  parameter int NUM_AUX_IN = 9,
  parameter int SLOT_TICKS = 8,
  parameter int CH_W       = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  cfg_fast,
  input  logic [NUM_AUX_IN-1:0] cfg_aux_en,
  output logic                  adc_req,
  output logic [CH_W-1:0]       adc_ch,
  output logic                  loop_done,
  output logic                  pre_cell_evt,
  output logic [CH_W-1:0]       pre_cell_idx
);
  localparam int FIRST_IN = NUM_CELLS + cml_pkg::FIXED_NODES + NUM_REFS;
  localparam int NUM_CH   = FIRST_IN + NUM_AUX_IN;
  localparam int TICK_W   = $clog2(SLOT_TICKS + 1);

  logic                  primed_q;
  logic [TICK_W-1:0]     tick_cnt_q;
  logic [CH_W-1:0]       pos_q;
  logic                  fast_q;
  logic [NUM_AUX_IN-1:0] en_q;
  logic [CH_W-1:0]       last_ch_q;

  int   slot_len_i;
  int   nxt_i;
  logic at_end;
  logic at_pre;
  logic slot_start;
  logic wrap;

  always_comb begin
    slot_len_i = cml_pkg::slot_ticks(SLOT_TICKS, fast_q);
    nxt_i      = primed_q ? cml_pkg::next_slot(int'(pos_q), 32'(en_q), FIRST_IN, NUM_AUX_IN) : 0;
    // Before the first loop a two-tick lead-in gives cell 0 its pause tick.
    at_end     = primed_q ? (int'(tick_cnt_q) == slot_len_i - 1) : (int'(tick_cnt_q) == 1);
    at_pre     = primed_q ? (int'(tick_cnt_q) == slot_len_i - 2) : (int'(tick_cnt_q) == 0);
    slot_start = tick && at_end;
    wrap       = slot_start && primed_q && (nxt_i == 0);
  end

  assign pre_cell_evt = tick && at_pre && (nxt_i < NUM_CELLS);
  assign pre_cell_idx = CH_W'(nxt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q   <= 1'b0;
      tick_cnt_q <= '0;
      pos_q      <= '0;
      fast_q     <= 1'b0;
      en_q       <= '0;
    end else if (tick) begin
      if (at_end) begin
        tick_cnt_q <= '0;
        pos_q      <= CH_W'(nxt_i);
        primed_q   <= 1'b1;
        if (!primed_q || nxt_i == 0) begin
          fast_q <= cfg_fast;
          en_q   <= cfg_aux_en;
        end
      end else begin
        tick_cnt_q <= tick_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_req   <= 1'b0;
      adc_ch    <= '0;
      last_ch_q <= '0;
      loop_done <= 1'b0;
    end else begin
      adc_req   <= slot_start;
      loop_done <= wrap;
      if (slot_start) begin
        adc_ch    <= CH_W'(nxt_i);
        last_ch_q <= adc_ch;
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |=> !adc_req); // R4
  AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |-> (int'(adc_ch) < NUM_CH)); // R2
  AST_CELL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && adc_ch != '0 && int'(adc_ch) < NUM_CELLS) |-> (int'(last_ch_q) == int'(adc_ch) - 1)); // R1
  AST_AUX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && int'(adc_ch) >= NUM_CELLS) |->
      ((int'(last_ch_q) == int'(adc_ch) - 1) ||
       (int'(adc_ch) >= FIRST_IN && int'(last_ch_q) >= FIRST_IN - 1 && last_ch_q < adc_ch))); // R2
  AST_WRAP_AT_CELL0: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> (adc_req && adc_ch == '0)); // R6
  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (int'(tick_cnt_q) < slot_len_i)); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !wrap) |=> ($stable(fast_q) && $stable(en_q))); // R7

endmodule

// File: rtl/cml_bal_hold.sv
module cml_bal_hold #(
  parameter int NUM_CELLS = 16,
  parameter int CH_W      = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pre_evt,
  input  logic [CH_W-1:0]      pre_idx,
  input  logic                 adc_req,
  input  logic [CH_W-1:0]      adc_ch,
  input  logic                 adc_done,
  output logic [NUM_CELLS-1:0] bal_pause
);
  logic [NUM_CELLS-1:0] ch_hit;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic hold_q;
    assign ch_hit[c]    = (int'(adc_ch) == c);
    assign bal_pause[c] = hold_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                               hold_q <= 1'b0;
      else if (pre_evt && int'(pre_idx) == c)   hold_q <= 1'b1;
      else if (adc_done && ch_hit[c])           hold_q <= 1'b0;
    end
  end

  AST_PAUSE_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && |ch_hit) |-> |(ch_hit & bal_pause)); // R5
  AST_PAUSE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && |ch_hit) |=> !(|(ch_hit & bal_pause))); // R5
  AST_PAUSE_FEW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bal_pause) <= 2); // R5

endmodule

// File: rtl/cml_result_bank.sv
module cml_result_bank #(
  parameter int NUM_CH = 29,
  parameter int DATA_W = 16,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_req,
  input  logic [CH_W-1:0]   adc_ch,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data
);
  logic              pending_q;
  logic              wr_en;
  logic [DATA_W-1:0] bank_q [NUM_CH];

  assign wr_en = adc_done && pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (adc_req)  pending_q <= 1'b1;
    else if (adc_done) pending_q <= 1'b0;
  end

  for (genvar e = 0; e < NUM_CH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                               bank_q[e] <= '0;
      else if (wr_en && int'(adc_ch) == e)      bank_q[e] <= adc_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_ch) < NUM_CH) rd_data = bank_q[rd_ch];
  end

  AST_REQ_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |=> pending_q); // R8
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && !adc_req) |=> !pending_q); // R8

endmodule

// File: rtl/cell_meas_loop_seq.sv
module cell_meas_loop_seq #(
  parameter  int NUM_CELLS  = 16,
  parameter  int NUM_REFS   = 1,
  parameter  int NUM_AUX_IN = 9,
  parameter  int DATA_W     = 16,
  parameter  int PRESCALE   = 4,
  parameter  int SLOT_TICKS = 8,
  localparam int NUM_CH     = NUM_CELLS + cml_pkg::FIXED_NODES + NUM_REFS + NUM_AUX_IN,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_fast,
  input  logic [NUM_AUX_IN-1:0] cfg_aux_en,
  output logic                  adc_req,
  output logic [CH_W-1:0]       adc_ch,
  input  logic                  adc_done,
  input  logic [DATA_W-1:0]     adc_data,
  output logic [NUM_CELLS-1:0]  bal_pause,
  output logic                  loop_done,
  input  logic [CH_W-1:0]       rd_ch,
  output logic [DATA_W-1:0]     rd_data
);
  logic            tick;
  logic            pre_cell_evt;
  logic [CH_W-1:0] pre_cell_idx;

  cml_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick)
  );

  cml_slot_sched #(
    .NUM_CELLS (NUM_CELLS),
    .NUM_REFS (NUM_REFS),
    .NUM_AUX_IN (NUM_AUX_IN),
    .SLOT_TICKS (SLOT_TICKS),
    .CH_W (CH_W)
  ) u_sched (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick),
    .cfg_fast (cfg_fast),
    .cfg_aux_en (cfg_aux_en),
    .adc_req (adc_req),
    .adc_ch (adc_ch),
    .loop_done (loop_done),
    .pre_cell_evt (pre_cell_evt),
    .pre_cell_idx (pre_cell_idx)
  );

  cml_bal_hold #(.NUM_CELLS(NUM_CELLS), .CH_W(CH_W)) u_bal (
    .clk (clk),
    .rst_n (rst_n),
    .pre_evt (pre_cell_evt),
    .pre_idx (pre_cell_idx),
    .adc_req (adc_req),
    .adc_ch (adc_ch),
    .adc_done (adc_done),
    .bal_pause (bal_pause)
  );

  cml_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_bank (
    .clk (clk),
    .rst_n (rst_n),
    .adc_req (adc_req),
    .adc_ch (adc_ch),
    .adc_done (adc_done),
    .adc_data (adc_data),
    .rd_ch (rd_ch),
    .rd_data (rd_data)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> !loop_done); // R6

endmodule

// File: tb/cell_meas_loop_seq_bench.sv
`timescale 1ns/1ps
module cell_meas_loop_seq_bench;
  localparam int PRE   = 4;
  localparam int TK    = 8;
  localparam int NC    = 16;
  localparam int NR    = 1;
  localparam int NA    = 9;
  localparam int DW    = 16;
  localparam int FIRST = NC + 3 + NR;
  localparam int NCH   = FIRST + NA;
  localparam int CHW   = $clog2(NCH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_fast = 1'b0;
  logic [NA-1:0]  cfg_aux_en = '0;
  logic           adc_req;
  logic [CHW-1:0] adc_ch;
  logic           adc_done = 1'b0;
  logic [DW-1:0]  adc_data = '0;
  logic [NC-1:0]  bal_pause;
  logic           loop_done;
  logic [CHW-1:0] rd_ch = '0;
  logic [DW-1:0]  rd_data;

  cell_meas_loop_seq #(
    .NUM_CELLS(NC), .NUM_REFS(NR), .NUM_AUX_IN(NA),
    .DATA_W(DW), .PRESCALE(PRE), .SLOT_TICKS(TK)
  ) u_cell_meas_loop_seq (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .cfg_aux_en(cfg_aux_en),
    .adc_req(adc_req), .adc_ch(adc_ch), .adc_done(adc_done), .adc_data(adc_data),
    .bal_pause(bal_pause), .loop_done(loop_done), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Scoreboard: expected channel and spacing of each request
  typedef struct { int ch; int gap; } exp_t;
  exp_t exp_q[$];
  int   prev_len = 0;

  task automatic push_loop(input bit fast, input logic [NA-1:0] en);
    for (int c = 0; c < NCH; c++) begin
      bit take;
      take = (c < FIRST);
      if (c >= FIRST) take = en[c - FIRST];
      if (take) begin
        exp_q.push_back('{c, prev_len * PRE});
        prev_len = fast ? TK / 2 : TK;
      end
    end
  endtask

  // Monitor
  int            last_req_cyc = 0;
  int            rise_cyc [NC];
  logic [NC-1:0] prev_pause = '0;
  bit            prev_req = 1'b0;
  bit            seen_first = 1'b0;
  int            n_ch5 = 0;
  int            n_loops = 0;
  int            held_ch = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++)
        if (bal_pause[c] && !prev_pause[c]) rise_cyc[c] = cyc;
      prev_pause = bal_pause;
      if (adc_req && prev_req) check(1'b0, "R4 request wider than one clock", 1, 0);
      if (!adc_req && int'(adc_ch) != held_ch) check(1'b0, "R4 channel moved between requests", int'(adc_ch), held_ch);
      if (!adc_req && loop_done) check(1'b0, "R6 loop_done without request", 1, 0);
      if (adc_req) begin
        int ch_i;
        ch_i = int'(adc_ch);
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(ch_i == e.ch, (e.ch < NC) ? "R1 cell channel order" : "R2/R7 aux channel order", ch_i, e.ch);
          if (e.gap > 0)
            check(cyc - last_req_cyc == e.gap, "R3/R7 request spacing", cyc - last_req_cyc, e.gap);
          check(loop_done == (e.ch == 0 && seen_first), "R6 loop_done at loop start",
                longint'(loop_done), longint'(e.ch == 0 && seen_first));
          if (!seen_first) check(ch_i == 0, "R9 first request channel", ch_i, 0);
        end
        if (ch_i < NC) begin
          check(bal_pause[ch_i] == 1'b1, "R5 pause held at request", longint'(bal_pause[ch_i]), 1);
          check(cyc - rise_cyc[ch_i] == PRE, "R5 pause lead of one tick", cyc - rise_cyc[ch_i], PRE);
        end
        if (loop_done) n_loops++;
        if (ch_i == 5) n_ch5++;
        seen_first   = 1'b1;
        last_req_cyc = cyc;
        held_ch      = ch_i;
      end
      prev_req = adc_req;
    end
  end

  // Converter model
  logic [DW-1:0] last_data [NCH];
  int  seq = 0;
  bit  stray_done = 1'b0;
  bit  final_phase = 1'b0;

  initial begin
    int ch;
    logic [DW-1:0] val;
    for (int i = 0; i < NCH; i++) last_data[i] = '0;
    forever begin
      @(negedge clk);
      if (rst_n && adc_req) begin
        ch = int'(adc_ch);
        repeat (3) @(negedge clk);
        val = DW'(seq * 32 + ch);
        adc_data = val;
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        last_data[ch] = val;
        seq++;
        if (!final_phase) begin
          rd_ch = CHW'(ch);
          #1;
          check(rd_data == val, "R8 result stored", rd_data, val);
          if (ch < NC) check(bal_pause[ch] == 1'b0, "R5 pause released after done", longint'(bal_pause[ch]), 0);
          if (!stray_done && n_loops >= 1 && ch == 3) begin
            @(negedge clk);
            adc_data = '1;
            adc_done = 1'b1;
            @(negedge clk);
            adc_done = 1'b0;
            #1;
            check(rd_data == val, "R8 stray done ignored", rd_data, val);
            stray_done = 1'b1;
          end
        end
      end
    end
  end

  // Driver
  bit            sc_fast [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
  logic [NA-1:0] sc_en   [4] = '{9'h1FF, 9'h005, 9'h000, 9'h100};

  initial begin
    int target;
    repeat (4) @(negedge clk);
    rd_ch = CHW'(3);
    #1;
    check(adc_req == 1'b0, "R9 no request in reset", longint'(adc_req), 0);
    check(loop_done == 1'b0, "R9 no loop_done in reset", longint'(loop_done), 0);
    check(bal_pause == '0, "R9 no pause in reset", longint'(bal_pause), 0);
    check(rd_data == '0, "R9 bank clear in reset", rd_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    push_loop(1'b0, '0);
    for (int s = 0; s < 4; s++) begin
      wait (n_ch5 == s + 1);
      cfg_fast   = sc_fast[s];
      cfg_aux_en = sc_en[s];
      push_loop(sc_fast[s], sc_en[s]);
    end
    wait (exp_q.size() == 0);
    final_phase = 1'b1;
    target = n_loops + 1;
    wait (n_loops == target);
    for (int ch = 1; ch < NCH; ch++) begin
      rd_ch = CHW'(ch);
      #1;
      check(rd_data == last_data[ch], "R8 entry retained", rd_data, last_data[ch]);
      @(negedge clk);
    end
    rd_ch = '1;
    #1;
    check(rd_data == '0, "R8 out-of-range read", rd_data, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule